// File: doc/BRIEF.md
# Credit-Based Secure Message Thread Pair

This block joins two hosts through a pair of one-way message threads. Thread 0 can only transmit and thread 1 can only receive. Each thread occupies a 4 KB window that holds a status word and fifteen data words, and a separate control region reports the direction of each thread. A message is fifteen 32-bit words. The producer on port 0 fills the transmit thread's data words, and its write of the final word sends the message. The consumer on port 1 reads the oldest pending message word by word, and its read of the final word retires that message.

Flow control uses credits. The transmit thread starts with one credit per slot of the internal message queue. Every accepted send spends one credit, and every retired message returns one. On the transmit thread the status count shows the credits still available. On the receive thread it shows the number of pending messages. A sticky error bit in each status word records misuse, and software clears it by writing a one to that bit. An interrupt output stays high while messages are pending. Each port reaches only its own thread, so the two hosts can operate in the same clock cycle.

Top module: `sp_msg_link`

## Requirements
- R1: After reset the transmit status reads 0x00000004 (4 credits, no error), the receive status reads 0x00000000, all transmit data words read 0 and rx_irq is low.
- R2: Port p reaches its status at byte address p*0x1000 and its data word i (0..14) at p*0x1000 + 4 + 4*i. Its control word is at 0x8000 + 0x1000 + p*0x1000. Bit 31 of the control word is the direction, 0 for thread 0 (transmit) and 1 for thread 1 (receive), and writes to the control word do not change it.
- R3: Transmit status bits 7:0 hold the remaining credits. A write of data word 14 while credits are nonzero sends one message and decrements the credits by one. The message carries the last values written to words 0..13 and the written word 14. Transmit data words read back their last written value.
- R4: Receive status bits 7:0 hold the pending count. A read of data word i returns word i of the oldest pending message. A read of word 14 while messages are pending retires that message and returns one credit to the transmit thread.
- R5: Up to 4 messages can be pending at once, and they are delivered in send order. Credits plus pending messages always total 4.
- R6: Status bit 31 is a sticky error flag. It is set by a word-14 write with zero credits, in which case the message is dropped and the credits stay 0. It is set by any data write to the receive thread, which leaves the pending count and the message contents unchanged. It is set by a word-14 read with nothing pending, which returns 0. Writing status with bit 31 = 1 clears the flag, and writing it with bit 31 = 0 leaves the flag set.
- R7: rx_irq is high exactly while the receive pending count is nonzero.
- R8: A send and a retire may occur in the same cycle. In that case both take effect, so the credits and the pending count end unchanged. The credit check uses the count from before the cycle, so a send attempted at zero credits is rejected and flagged even if a retire returns a credit in that same cycle.
- R9: A port's access to the other thread's window or control word reads 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_req | input | 1 | Port 0 (producer) access strobe |
| p0_we | input | 1 | Port 0 write when 1, read when 0 |
| p0_addr | input | 16 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, valid in the cycle of the access |
| p1_req | input | 1 | Port 1 (consumer) access strobe |
| p1_we | input | 1 | Port 1 write when 1, read when 0 |
| p1_addr | input | 16 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, valid in the cycle of the access |
| rx_irq | output | 1 | High while receive messages are pending |

## Verification
A send of the final word on port 0 and a retire of the final word on port 1 can fall in the same clock edge. When they do, the credit counter and the pending counter each receive an increment and a decrement at once. The bench provokes this by staging words 0..13 and then driving both final-word accesses together in one cycle, once with one message pending and once with the queue full and no credits left. It judges the result from both status words read afterwards, from the word returned by the retiring read, and from the order and content of the messages drained later. In the full case it also checks that the rejected send is flagged while the returned credit still appears.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 16;
    localparam int MSG_WORDS   = 15;
    localparam int CNT_W       = 8;
    localparam int IDX_W       = $clog2(MSG_WORDS);
    localparam int SPAN_LG     = 12;
    localparam int SLOT_W      = ADDR_W - 1 - SPAN_LG;
    localparam int WSEL_W      = SPAN_LG - 2;
    localparam int ERR_BIT     = 31;
    localparam int DIR_BIT     = 31;
    localparam int LAST_IDX    = MSG_WORDS - 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef word_t [MSG_WORDS-1:0] msg_t;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_CTRL   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        acc_kind_e         kind;
        logic [IDX_W-1:0]  idx;
        word_t             wdata;
    } acc_t;

    function automatic word_t status_word(input logic err, input logic [CNT_W-1:0] cnt);
        word_t w;
        w = '0;
        w[ERR_BIT] = err;
        w[CNT_W-1:0] = cnt;
        return w;
    endfunction

    function automatic word_t ctrl_word(input logic is_rx);
        word_t w;
        w = '0;
        w[DIR_BIT] = is_rx;
        return w;
    endfunction

endpackage

// File: rtl/sp_port_decode.sv
module sp_port_decode
    import sp_pkg::*;
#(
    parameter int PORT_TID = 0
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output acc_t              acc
);
    localparam logic [SLOT_W-1:0] OWN_SLOT  = SLOT_W'(PORT_TID);
    localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(PORT_TID + 1);

    logic              in_ctrl_region;
    logic [SLOT_W-1:0] slot;
    logic [WSEL_W-1:0] wsel;
    logic              aligned;
    acc_kind_e         kind;

    assign in_ctrl_region = addr[ADDR_W-1];
    assign slot           = addr[ADDR_W-2:SPAN_LG];
    assign wsel           = addr[SPAN_LG-1:2];
    assign aligned        = (addr[1:0] == 2'b00);

    always_comb begin
        kind = ACC_NONE;
        if (aligned) begin
            if (!in_ctrl_region && slot == OWN_SLOT) begin
                if (wsel == '0)
                    kind = ACC_STATUS;
                else if (wsel <= WSEL_W'(MSG_WORDS))
                    kind = ACC_DATA;
            end else if (in_ctrl_region && slot == CTRL_SLOT && wsel == '0) begin
                kind = ACC_CTRL;
            end
        end
    end

    always_comb begin
        acc.valid = req && (kind != ACC_NONE);
        acc.we    = we;
        acc.kind  = kind;
        acc.idx   = IDX_W'(wsel - 1'b1);
        acc.wdata = wdata;
    end

endmodule

// File: rtl/sp_tx_thread.sv
module sp_tx_thread
    import sp_pkg::*;
#(
    parameter int CREDITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic             credit_ret,
    output word_t            rdata,
    output logic             send,
    output msg_t             msg,
    output logic [CNT_W-1:0] credits_o
);
    word_t            stage [MSG_WORDS];
    logic [CNT_W-1:0] credits;
    logic [CNT_W-1:0] credits_nxt;
    logic             err;
    logic             data_wr;
    logic             send_try;
    logic             err_set;
    logic             err_clr;

    assign data_wr  = acc.valid && acc.we && acc.kind == ACC_DATA;
    assign send_try = data_wr && acc.idx == IDX_W'(LAST_IDX);
    assign send     = send_try && credits != '0;
    assign err_set  = send_try && credits == '0;
    assign err_clr  = acc.valid && acc.we && acc.kind == ACC_STATUS && acc.wdata[ERR_BIT];

    always_comb begin
        credits_nxt = credits;
        if (send)
            credits_nxt = credits_nxt - 1'b1;
        if (credit_ret)
            credits_nxt = credits_nxt + 1'b1;
    end

    for (genvar i = 0; i < MSG_WORDS; i++) begin : g_msg
        if (i == LAST_IDX) begin : g_last
            assign msg[i] = acc.wdata;
        end else begin : g_body
            assign msg[i] = stage[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credits <= CNT_W'(CREDITS);
            err     <= 1'b0;
            for (int i = 0; i < MSG_WORDS; i++)
                stage[i] <= '0;
        end else begin
            credits <= credits_nxt;
            err     <= err_set || (err && !err_clr);
            if (data_wr)
                stage[acc.idx] <= acc.wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.valid) begin
            case (acc.kind)
                ACC_STATUS: rdata = status_word(err, credits);
                ACC_DATA:   rdata = stage[acc.idx];
                ACC_CTRL:   rdata = ctrl_word(1'b0);
                default:    rdata = '0;
            endcase
        end
    end

    assign credits_o = credits;

    p_credit_bound_r5: assert property (@(posedge clk) disable iff (rst)
        credits <= CNT_W'(CREDITS));

    p_send_spends_r3: assert property (@(posedge clk) disable iff (rst)
        (send && !credit_ret) |=> credits == CNT_W'($past(credits) - 1'b1));

    p_dry_send_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (send_try && credits == '0) |=> (err && credits == CNT_W'($past(credit_ret))));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err);

endmodule

// File: rtl/sp_rx_thread.sv
module sp_rx_thread
    import sp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic             push,
    input  msg_t             push_msg,
    output word_t            rdata,
    output logic             credit_ret,
    output logic [CNT_W-1:0] pending_o,
    output logic             irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    msg_t             mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nxt;
    logic             err;
    logic             pop_try;
    logic             pop;
    logic             err_set;
    logic             err_clr;
    logic             bad_write;
    msg_t             head;
    logic             unused_wdata;

    assign unused_wdata = ^acc.wdata;

    assign pop_try   = acc.valid && !acc.we && acc.kind == ACC_DATA && acc.idx == IDX_W'(LAST_IDX);
    assign pop       = pop_try && count != '0;
    assign bad_write = acc.valid && acc.we && acc.kind == ACC_DATA;
    assign err_set   = bad_write || (pop_try && count == '0);
    assign err_clr   = acc.valid && acc.we && acc.kind == ACC_STATUS && acc.wdata[ERR_BIT];
    assign head      = mem[rp];

    always_comb begin
        count_nxt = count;
        if (push)
            count_nxt = count_nxt + 1'b1;
        if (pop)
            count_nxt = count_nxt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= push_msg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            err   <= 1'b0;
        end else begin
            count <= count_nxt;
            err   <= err_set || (err && !err_clr);
            if (push)
                wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (pop)
                rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.valid) begin
            case (acc.kind)
                ACC_STATUS: rdata = status_word(err, count);
                ACC_DATA:   rdata = (count != '0) ? head[acc.idx] : '0;
                ACC_CTRL:   rdata = ctrl_word(1'b1);
                default:    rdata = '0;
            endcase
        end
    end

    assign credit_ret = pop;
    assign pending_o  = count;
    assign irq        = (count != '0);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> count < CNT_W'(DEPTH));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(push));

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(1) && pop && !push) |=> !irq);

    p_bad_write_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (bad_write && !push) |=> (err && $stable(count)));

endmodule

// File: rtl/sp_msg_link.sv
module sp_msg_link
    import sp_pkg::*;
#(
    parameter int CREDITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_req,
    input  logic              p0_we,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_req,
    input  logic              p1_we,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              rx_irq
);
    localparam int NPORTS = 2;

    logic              req_v   [NPORTS];
    logic              we_v    [NPORTS];
    logic [ADDR_W-1:0] addr_v  [NPORTS];
    word_t             wdata_v [NPORTS];
    acc_t              acc_v   [NPORTS];

    assign req_v[0]   = p0_req;
    assign we_v[0]    = p0_we;
    assign addr_v[0]  = p0_addr;
    assign wdata_v[0] = p0_wdata;
    assign req_v[1]   = p1_req;
    assign we_v[1]    = p1_we;
    assign addr_v[1]  = p1_addr;
    assign wdata_v[1] = p1_wdata;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        sp_port_decode #(.PORT_TID(p)) u_dec (
            .req   (req_v[p]),
            .we    (we_v[p]),
            .addr  (addr_v[p]),
            .wdata (wdata_v[p]),
            .acc   (acc_v[p])
        );
    end

    logic             send;
    logic             credit_ret;
    msg_t             msg;
    logic [CNT_W-1:0] tx_credits;
    logic [CNT_W-1:0] rx_pending;

    sp_tx_thread #(.CREDITS(CREDITS)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc_v[0]),
        .credit_ret (credit_ret),
        .rdata      (p0_rdata),
        .send       (send),
        .msg        (msg),
        .credits_o  (tx_credits)
    );

    sp_rx_thread #(.DEPTH(CREDITS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc_v[1]),
        .push       (send),
        .push_msg   (msg),
        .rdata      (p1_rdata),
        .credit_ret (credit_ret),
        .pending_o  (rx_pending),
        .irq        (rx_irq)
    );

    p_credit_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_credits) + int'(rx_pending)) == CREDITS);

    p_simul_balance_r8: assert property (@(posedge clk) disable iff (rst)
        (send && credit_ret) |=> ($stable(tx_credits) && $stable(rx_pending)));

endmodule

// File: tb/sp_msg_link_tb_top.sv
`timescale 1ns/1ps
module sp_msg_link_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p0_req = 1'b0, p0_we = 1'b0, p1_req = 1'b0, p1_we = 1'b0;
    logic [15:0] p0_addr = '0, p1_addr = '0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic        rx_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sp_msg_link dut_i (
        .clk(clk), .rst(rst),
        .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mw(input int seed, input int i);
        return {8'(seed), 8'h5A, 8'h00, 8'(i)};
    endfunction

    task automatic bus(input int p, input logic we, input logic [15:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        if (p == 0) begin p0_req = 1; p0_we = we; p0_addr = a; p0_wdata = d; end
        else        begin p1_req = 1; p1_we = we; p1_addr = a; p1_wdata = d; end
        #1;
        q = (p == 0) ? p0_rdata : p1_rdata;
        @(posedge clk);
        #1;
        p0_req = 0; p1_req = 0;
    endtask

    task automatic dual(input logic [15:0] a0, input logic [31:0] d0, input logic [15:0] a1,
                        output logic [31:0] q1);
        @(negedge clk);
        p0_req = 1; p0_we = 1; p0_addr = a0; p0_wdata = d0;
        p1_req = 1; p1_we = 0; p1_addr = a1; p1_wdata = '0;
        #1;
        q1 = p1_rdata;
        @(posedge clk);
        #1;
        p0_req = 0; p1_req = 0;
    endtask

    task automatic wr(input int p, input logic [15:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(p, 1'b1, a, d, q);
    endtask

    task automatic rd(input int p, input logic [15:0] a, output logic [31:0] q);
        bus(p, 1'b0, a, '0, q);
    endtask

    task automatic stage_body(input int seed);
        for (int i = 0; i < 14; i++) wr(0, 16'(4 + 4 * i), mw(seed, i));
    endtask

    task automatic send_msg(input int seed);
        stage_body(seed);
        wr(0, 16'h003C, mw(seed, 14));
    endtask

    task automatic recv_check(input int seed, input string tag);
        logic [31:0] q;
        for (int i = 0; i < 15; i++) begin
            rd(1, 16'(16'h1004 + 4 * i), q);
            check(tag, q, mw(seed, i));
        end
    endtask

    task automatic t_reset;
        logic [31:0] q;
        rd(0, 16'h0000, q); check("R1 tx status", q, 32'h4);
        rd(1, 16'h1000, q); check("R1 rx status", q, 32'h0);
        rd(0, 16'h0004, q); check("R1 tx word0", q, 32'h0);
        check("R1 irq", {31'b0, rx_irq}, 32'h0);
        rd(0, 16'h9000, q); check("R2 ctrl thread0", q, 32'h0);
        rd(1, 16'hA000, q); check("R2 ctrl thread1", q, 32'h8000_0000);
    endtask

    task automatic t_ctrl_locked;
        logic [31:0] q;
        wr(0, 16'h9000, 32'hFFFF_FFFF);
        wr(1, 16'hA000, 32'h0);
        rd(0, 16'h9000, q); check("R2 ctrl0 locked", q, 32'h0);
        rd(1, 16'hA000, q); check("R2 ctrl1 locked", q, 32'h8000_0000);
    endtask

    task automatic t_single;
        logic [31:0] q;
        stage_body(1);
        rd(0, 16'h0014, q); check("R3 stage readback", q, mw(1, 4));
        rd(1, 16'h1000, q); check("R3 no send before word14", q, 32'h0);
        wr(0, 16'h003C, mw(1, 14));
        rd(0, 16'h0000, q); check("R3 credit spent", q, 32'h3);
        rd(1, 16'h1000, q); check("R4 pending one", q, 32'h1);
        check("R7 irq high", {31'b0, rx_irq}, 32'h1);
        recv_check(1, "R4 message words");
        rd(1, 16'h1000, q); check("R4 pending zero", q, 32'h0);
        rd(0, 16'h0000, q); check("R4 credit returned", q, 32'h4);
        check("R7 irq low", {31'b0, rx_irq}, 32'h0);
    endtask

    task automatic t_order_full;
        logic [31:0] q;
        for (int s = 2; s < 6; s++) send_msg(s);
        rd(0, 16'h0000, q); check("R5 credits exhausted", q, 32'h0);
        rd(1, 16'h1000, q); check("R5 four pending", q, 32'h4);
        send_msg(9);
        rd(0, 16'h0000, q); check("R6 zero-credit send flagged", q, 32'h8000_0000);
        rd(1, 16'h1000, q); check("R6 dropped send", q, 32'h4);
        wr(0, 16'h0000, 32'h0000_0000);
        rd(0, 16'h0000, q); check("R6 write 0 keeps error", q, 32'h8000_0000);
        wr(0, 16'h0000, 32'h8000_0000);
        rd(0, 16'h0000, q); check("R6 error cleared", q, 32'h0);
        for (int s = 2; s < 6; s++) recv_check(s, "R5 in-order delivery");
        rd(0, 16'h0000, q); check("R5 credits restored", q, 32'h4);
    endtask

    task automatic t_empty;
        logic [31:0] q;
        rd(1, 16'h103C, q); check("R6 empty consume data", q, 32'h0);
        rd(1, 16'h1000, q); check("R6 empty consume flagged", q, 32'h8000_0000);
        rd(0, 16'h0000, q); check("R6 empty consume credits", q, 32'h4);
        wr(1, 16'h1000, 32'h8000_0000);
        rd(1, 16'h1000, q); check("R6 rx error cleared", q, 32'h0);
    endtask

    task automatic t_rx_write;
        logic [31:0] q;
        send_msg(40);
        wr(1, 16'h1010, 32'hDEAD_BEEF);
        rd(1, 16'h1000, q); check("R6 rx data write flagged", q, 32'h8000_0001);
        wr(1, 16'h1000, 32'h0000_0001);
        rd(1, 16'h1000, q); check("R6 rx write 0 keeps error", q, 32'h8000_0001);
        recv_check(40, "R6 content untouched");
        wr(1, 16'h1000, 32'h8000_0000);
        rd(1, 16'h1000, q); check("R6 rx clear", q, 32'h0);
    endtask

    task automatic t_foreign;
        logic [31:0] q;
        send_msg(30);
        rd(0, 16'h1000, q); check("R9 port0 sees no rx status", q, 32'h0);
        rd(0, 16'hA000, q); check("R9 port0 sees no rx ctrl", q, 32'h0);
        wr(0, 16'h103C, 32'h1234_5678);
        rd(1, 16'h1000, q); check("R9 port0 write into rx ignored", q, 32'h1);
        rd(1, 16'h0004, q); check("R9 port1 sees no tx data", q, 32'h0);
        wr(1, 16'h003C, 32'h1111_2222);
        rd(0, 16'h0000, q); check("R9 port1 cannot send", q, 32'h3);
        rd(1, 16'h1000, q); check("R9 pending unchanged", q, 32'h1);
        recv_check(30, "R9 message intact");
    endtask

    task automatic t_simul;
        logic [31:0] q;
        send_msg(10);
        stage_body(11);
        dual(16'h003C, mw(11, 14), 16'h103C, q);
        check("R8 retire returns old word", q, mw(10, 14));
        rd(0, 16'h0000, q); check("R8 credits balanced", q, 32'h3);
        rd(1, 16'h1000, q); check("R8 pending balanced", q, 32'h1);
        recv_check(11, "R8 new message delivered");
        for (int s = 20; s < 24; s++) send_msg(s);
        stage_body(24);
        dual(16'h003C, mw(24, 14), 16'h103C, q);
        check("R8 full retire word", q, mw(20, 14));
        rd(0, 16'h0000, q); check("R8 stale-count reject", q, 32'h8000_0001);
        rd(1, 16'h1000, q); check("R8 pending after reject", q, 32'h3);
        wr(0, 16'h0000, 32'h8000_0000);
        for (int s = 21; s < 24; s++) recv_check(s, "R8 drain order");
        rd(0, 16'h0000, q); check("R8 final credits", q, 32'h4);
        check("R7 irq idle", {31'b0, rx_irq}, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset;
        t_ctrl_locked;
        t_single;
        t_order_full;
        t_empty;
        t_rx_write;
        t_foreign;
        t_simul;
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (R1..all): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule